// File: doc/BRIEF.md
# UART Receive Status and Flow-Control Unit

This block is the receive-side control of a UART. A deserializer outside the block signals a detected start bit with a one-cycle strobe. When a character is complete it presents a one-cycle push that carries the data byte and three status flags: break, framing error and parity error. The unit keeps these characters in a small FIFO. It reports status, drives the receiver's RTS flow-control output, and raises one request line that an interrupt controller or a DMA engine can use.

Software reaches the block through a small register bus with four word addresses. Two mode registers share address 0 and are selected by an internal pointer. After reset, or after the pointer-reset command, the pointer selects mode register A. Any access to mode register A moves the pointer to mode register B, and it stays there. The other addresses hold a side-effect-free status register, a data register whose read pops the FIFO, and a write-only command register.

Top module: `uart_rx_ctrl`

## Requirements
- R1: After reset, mode register A reads 0x00, the pointer selects mode register A, `rts_o` is 1 (asserted), `irq_o` is 0 and the status register reads 0x00.
- R2: A read or write at address 0 accesses mode register A when the pointer selects it and then moves the pointer to mode register B. Every later address-0 access reaches mode register B until reset or until command 0x01 is written to address 3.
- R3: The FIFO holds `DEPTH` entries, 4 by default. Status bit 0 (ready) is 1 whenever the FIFO is not empty, and status bit 1 (full) is 1 when it holds `DEPTH` entries. A read at address 2 returns the head byte and pops it; a read of an empty FIFO returns 0x00.
- R4: A push into a full FIFO in a cycle with no pop is dropped and sets status bit 2 (overrun), which stays set until command 0x02 is written to address 3. A push in the same cycle as a pop is accepted.
- R5: With mode register A bit 5 = 0, status bits 5, 4 and 3 show the break, framing and parity flags of the current head entry, or 0 when the FIFO is empty.
- R6: With mode register A bit 5 = 1, each of status bits 5:3 is the OR of that flag over every entry that has been at the FIFO head since the last 0x02 command, including the current head.
- R7: Receiver RTS control is enabled when mode register A bit 7 = 1 and mode register B bit 4 = 0. In that case a start-bit strobe while the FIFO is full drives `rts_o` to 0 on the next clock. `rts_o` returns to 1 on the clock after the FIFO has a free entry.
- R8: When mode register A bit 7 and mode register B bit 4 are both 1, or when bit 7 is 0, `rts_o` is 1 one clock later, whatever the FIFO state.
- R9: `irq_o` equals the ready status when mode register A bit 6 = 0 and the full status when it is 1.
- R10: Reading the status register (address 1) changes no state. Command writes other than 0x01 and 0x02 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | 0 mode, 1 status, 2 receive data, 3 command |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational, 0 when not reading |
| start_det_i | input | 1 | Valid start bit detected strobe |
| push_i | input | 1 | Character complete strobe |
| push_data_i | input | 8 | Received character |
| push_brk_i | input | 1 | Received break flag |
| push_fe_i | input | 1 | Framing error flag |
| push_pe_i | input | 1 | Parity error flag |
| rts_o | output | 1 | Receiver RTS, 1 = asserted |
| irq_o | output | 1 | Interrupt or DMA request |

## Verification
The bench targets the pointer. It checks that mode register B is never reached before register A has been accessed, and that the pointer never falls back to A without the command. A design that moved the pointer only on writes, or that toggled it, would return the wrong register on the second read. It fills the FIFO and then pushes and pops in the same cycle, to catch designs that drop an accepted character or miss an overrun. It also switches between character and block mode around the error-reset command. A design that accumulates only on push, or forgets the current head, would show stale or missing flags. Finally it strobes start bits with the FIFO full and with the invalid enable combination, where a wrong design would negate RTS too early or while control is disabled.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  parameter int unsigned CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              pe;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [1:0] {
    ADDR_MODE = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2,
    ADDR_CMD  = 2'd3
  } reg_addr_e;

  localparam logic [CHAR_W-1:0] CMD_RST_PTR = 8'h01;
  localparam logic [CHAR_W-1:0] CMD_RST_ERR = 8'h02;

  // mode register bit positions
  localparam int unsigned MRA_RXRTS = 7;
  localparam int unsigned MRA_IRQSEL = 6;
  localparam int unsigned MRA_BLOCK = 5;
  localparam int unsigned MRB_TXRTS = 4;
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  rx_entry_t       entry_i,
  input  logic            pop_i,
  output rx_entry_t       head_o,
  output logic [CW-1:0]   cnt_o,
  output logic            empty_o,
  output logic            full_o
);
  rx_entry_t     mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign head_o  = mem_q[rd_q];
  assign cnt_o   = cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[i] <= '0;
      else if (do_push && wr_q == AW'(i))     mem_q[i] <= entry_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_mode_regs.sv
module uart_rx_mode_regs
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [CHAR_W-1:0] wdata_i,
  input  logic              rst_ptr_i,
  output logic [CHAR_W-1:0] mra_o,
  output logic [CHAR_W-1:0] mrb_o,
  output logic [CHAR_W-1:0] rdata_o,
  output logic              ptr_b_o
);
  logic [CHAR_W-1:0] mra_q, mrb_q;
  logic              ptr_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mra_q   <= '0;
      mrb_q   <= '0;
      ptr_b_q <= 1'b0;
    end else begin
      if (rst_ptr_i) begin
        ptr_b_q <= 1'b0;
      end else if (acc_i) begin
        ptr_b_q <= 1'b1;
        if (we_i) begin
          if (ptr_b_q) mrb_q <= wdata_i;
          else         mra_q <= wdata_i;
        end
      end
    end
  end

  assign rdata_o = ptr_b_q ? mrb_q : mra_q;
  assign mra_o   = mra_q;
  assign mrb_o   = mrb_q;
  assign ptr_b_o = ptr_b_q;
endmodule

// File: rtl/uart_rx_err_stat.sv
module uart_rx_err_stat (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic       pop_i,
  input  logic       full_i,
  input  logic       empty_i,
  input  logic       clr_i,
  input  logic       block_mode_i,
  input  logic [2:0] head_fl_i,
  output logic [2:0] flags_o,
  output logic       ovr_o
);
  logic [2:0] acc_q, head_fl;
  logic       ovr_q, drop;

  assign head_fl = empty_i ? 3'b000 : head_fl_i;
  assign drop    = push_i && full_i && !(pop_i && !empty_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      acc_q <= clr_i ? 3'b000 : (acc_q | head_fl);
      if (drop)       ovr_q <= 1'b1;
      else if (clr_i) ovr_q <= 1'b0;
    end
  end

  assign flags_o = block_mode_i ? (acc_q | head_fl) : head_fl;
  assign ovr_o   = ovr_q;
endmodule

// File: rtl/uart_rx_rts.sv
module uart_rx_rts (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic full_i,
  output logic rts_o
);
  logic rts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rts_q <= 1'b1;
    else if (!en_i)             rts_q <= 1'b1;
    else if (start_i && full_i) rts_q <= 1'b0;
    else if (!full_i)           rts_q <= 1'b1;
  end

  assign rts_o = rts_q;
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [CHAR_W-1:0] bus_wdata_i,
  output logic [CHAR_W-1:0] bus_rdata_o,
  input  logic              start_det_i,
  input  logic              push_i,
  input  logic [CHAR_W-1:0] push_data_i,
  input  logic              push_brk_i,
  input  logic              push_fe_i,
  input  logic              push_pe_i,
  output logic              rts_o,
  output logic              irq_o
);
  logic              mode_acc, rd_stb, pop, rst_ptr, clr_err;
  logic [CHAR_W-1:0] mra, mrb, mode_rdata, stat_word;
  logic              ptr_b, fifo_empty, fifo_full, ovr, rx_rts_en;
  logic [CW-1:0]     fifo_cnt;
  logic [2:0]        flags;
  rx_entry_t         push_entry, head;

  assign rd_stb   = bus_en_i && !bus_we_i;
  assign mode_acc = bus_en_i && (bus_addr_i == ADDR_MODE);
  assign pop      = rd_stb && (bus_addr_i == ADDR_DATA);
  assign rst_ptr  = bus_en_i && bus_we_i && (bus_addr_i == ADDR_CMD) && (bus_wdata_i == CMD_RST_PTR);
  assign clr_err  = bus_en_i && bus_we_i && (bus_addr_i == ADDR_CMD) && (bus_wdata_i == CMD_RST_ERR);

  assign push_entry = '{brk: push_brk_i, fe: push_fe_i, pe: push_pe_i, data: push_data_i};

  uart_rx_mode_regs u_mode (
    .clk_i, .rst_ni,
    .acc_i     (mode_acc),
    .we_i      (bus_we_i),
    .wdata_i   (bus_wdata_i),
    .rst_ptr_i (rst_ptr),
    .mra_o     (mra),
    .mrb_o     (mrb),
    .rdata_o   (mode_rdata),
    .ptr_b_o   (ptr_b)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (push_i),
    .entry_i (push_entry),
    .pop_i   (pop),
    .head_o  (head),
    .cnt_o   (fifo_cnt),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  uart_rx_err_stat u_err (
    .clk_i, .rst_ni,
    .push_i       (push_i),
    .pop_i        (pop),
    .full_i       (fifo_full),
    .empty_i      (fifo_empty),
    .clr_i        (clr_err),
    .block_mode_i (mra[MRA_BLOCK]),
    .head_fl_i    ({head.brk, head.fe, head.pe}),
    .flags_o      (flags),
    .ovr_o        (ovr)
  );

  // invalid combination of both RTS controls disables receiver control
  assign rx_rts_en = mra[MRA_RXRTS] && !mrb[MRB_TXRTS];

  uart_rx_rts u_rts (
    .clk_i, .rst_ni,
    .en_i    (rx_rts_en),
    .start_i (start_det_i),
    .full_i  (fifo_full),
    .rts_o   (rts_o)
  );

  assign stat_word = {2'b00, flags, ovr, fifo_full, !fifo_empty};
  assign irq_o     = mra[MRA_IRQSEL] ? fifo_full : !fifo_empty;

  always_comb begin
    bus_rdata_o = '0;
    if (rd_stb) begin
      unique case (bus_addr_i)
        ADDR_MODE: bus_rdata_o = mode_rdata;
        ADDR_STAT: bus_rdata_o = stat_word;
        ADDR_DATA: bus_rdata_o = fifo_empty ? '0 : head.data;
        default:   bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_ctrl_chk.sv
module uart_rx_ctrl_chk #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rts_o,
  input logic          irq_o,
  input logic          rx_rts_en,
  input logic          start_det_i,
  input logic          push_i,
  input logic          pop,
  input logic          rst_ptr,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic [CW-1:0] fifo_cnt,
  input logic          ovr,
  input logic          ptr_b,
  input logic [7:0]    mra,
  input logic [7:0]    mrb
);
  // R7
  rts_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rts_en && start_det_i && fifo_full |=> !rts_o);

  // R7
  rts_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rts_en && !fifo_full |=> rts_o);

  // R8
  rts_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mra[7] && mrb[4] |=> rts_o);

  // R3
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));

  // R4
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && fifo_full && !pop |=> ovr && $stable(fifo_cnt));

  // R2
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_b && !rst_ptr |=> ptr_b);

  // R9
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_empty |-> !irq_o);
endmodule

bind uart_rx_ctrl uart_rx_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rts_o       (rts_o),
  .irq_o       (irq_o),
  .rx_rts_en   (rx_rts_en),
  .start_det_i (start_det_i),
  .push_i      (push_i),
  .pop         (pop),
  .rst_ptr     (rst_ptr),
  .fifo_full   (fifo_full),
  .fifo_empty  (fifo_empty),
  .fifo_cnt    (fifo_cnt),
  .ovr         (ovr),
  .ptr_b       (ptr_b),
  .mra         (mra),
  .mrb         (mrb)
);

// File: tb/uart_rx_ctrl_tb.sv
`timescale 1ns/1ps
module uart_rx_ctrl_tb;
  localparam int DEPTH = 4;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       bus_en_i = 0, bus_we_i = 0;
  logic [1:0] bus_addr_i = 0;
  logic [7:0] bus_wdata_i = 0, bus_rdata_o;
  logic       start_det_i = 0, push_i = 0;
  logic [7:0] push_data_i = 0;
  logic       push_brk_i = 0, push_fe_i = 0, push_pe_i = 0;
  logic       rts_o, irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  uart_rx_ctrl #(.DEPTH(DEPTH)) u_dut (.*);

  always #4 clk_i = ~clk_i;

  // reference model state
  logic [10:0] q[$];
  logic [7:0]  m_mra = 0, m_mrb = 0;
  bit          m_ptr_b = 0, m_ovr = 0, m_rts = 1;
  logic [2:0]  m_acc = 0;

  function automatic logic [2:0] head_fl();
    return (q.size() > 0) ? q[0][10:8] : 3'b000;
  endfunction

  function automatic logic [7:0] m_status();
    logic [2:0] f;
    f = m_mra[5] ? (m_acc | head_fl()) : head_fl();
    return {2'b00, f, m_ovr, q.size() == DEPTH, q.size() > 0};
  endfunction

  function automatic logic [7:0] m_rdata();
    if (!bus_en_i || bus_we_i) return 8'h00;
    case (bus_addr_i)
      2'd0: return m_ptr_b ? m_mrb : m_mra;
      2'd1: return m_status();
      2'd2: return (q.size() > 0) ? q[0][7:0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update();
    bit full, pop, clr, rptr;
    logic [2:0] hf;
    full = (q.size() == DEPTH);
    pop  = bus_en_i && !bus_we_i && bus_addr_i == 2'd2 && q.size() > 0;
    clr  = bus_en_i && bus_we_i && bus_addr_i == 2'd3 && bus_wdata_i == 8'h02;
    rptr = bus_en_i && bus_we_i && bus_addr_i == 2'd3 && bus_wdata_i == 8'h01;
    hf   = head_fl();
    if (!(m_mra[7] && !m_mrb[4])) m_rts = 1;
    else if (start_det_i && full) m_rts = 0;
    else if (!full)               m_rts = 1;
    if (push_i && full && !pop) m_ovr = 1;
    else if (clr)               m_ovr = 0;
    m_acc = clr ? 3'b000 : (m_acc | hf);
    if (pop) void'(q.pop_front());
    if (push_i && (!full || pop)) q.push_back({push_brk_i, push_fe_i, push_pe_i, push_data_i});
    if (rptr) m_ptr_b = 0;
    else if (bus_en_i && bus_addr_i == 2'd0) begin
      if (bus_we_i) begin
        if (m_ptr_b) m_mrb = bus_wdata_i; else m_mra = bus_wdata_i;
      end
      m_ptr_b = 1;
    end
  endtask

  // one clock: compare outputs for the applied inputs, then advance
  task automatic cycle(string tag);
    #1;
    check("R7", {7'd0, rts_o}, {7'd0, m_rts});
    check("R9", {7'd0, irq_o}, {7'd0, m_mra[6] ? (q.size() == DEPTH) : (q.size() > 0)});
    check(tag, bus_rdata_o, m_rdata());
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
    bus_en_i = 0; bus_we_i = 0; push_i = 0; start_det_i = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, string tag);
    bus_en_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    cycle(tag);
  endtask

  task automatic rd(logic [1:0] a, string tag);
    bus_en_i = 1; bus_we_i = 0; bus_addr_i = a;
    cycle(tag);
  endtask

  // read with an explicit hard expectation in addition to the model
  task automatic rd_exp(logic [1:0] a, logic [7:0] exp, string tag);
    bus_en_i = 1; bus_we_i = 0; bus_addr_i = a;
    #1 check(tag, bus_rdata_o, exp);
    cycle(tag);
  endtask

  task automatic push(logic [7:0] d, logic [2:0] fl, string tag);
    push_i = 1; push_data_i = d; {push_brk_i, push_fe_i, push_pe_i} = fl;
    cycle(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    #1 check("R1", {6'd0, rts_o, irq_o}, 8'h02);
    rd_exp(2'd1, 8'h00, "R1");
    rd_exp(2'd0, 8'h00, "R1");

    // R2 pointer: the read above moved it to register B
    wr(2'd0, 8'h5A, "R2");
    rd_exp(2'd0, 8'h5A, "R2");
    wr(2'd3, 8'h01, "R2");
    rd_exp(2'd0, 8'h00, "R2");
    rd_exp(2'd0, 8'h5A, "R2");
    wr(2'd3, 8'h07, "R10");
    rd_exp(2'd0, 8'h5A, "R10");
    wr(2'd3, 8'h01, "R2");
    wr(2'd0, 8'h00, "R2");
    wr(2'd0, 8'h00, "R2");

    // R3 / R5 character mode
    push(8'hA1, 3'b001, "R3");
    push(8'hB2, 3'b100, "R3");
    rd_exp(2'd1, 8'h09, "R5");
    rd_exp(2'd2, 8'hA1, "R3");
    rd_exp(2'd1, 8'h21, "R5");
    rd_exp(2'd2, 8'hB2, "R3");
    rd_exp(2'd2, 8'h00, "R3");

    // R4 overrun and simultaneous push/pop at full
    for (int i = 0; i < DEPTH; i++) push(8'h10 + 8'(i), 3'b000, "R3");
    rd_exp(2'd1, 8'h03, "R3");
    push(8'hEE, 3'b000, "R4");
    rd_exp(2'd1, 8'h07, "R4");
    rd_exp(2'd1, 8'h07, "R10");
    push_i = 1; push_data_i = 8'h77; {push_brk_i, push_fe_i, push_pe_i} = 3'b000;
    rd(2'd2, "R4");
    rd_exp(2'd1, 8'h07, "R4");
    wr(2'd3, 8'h02, "R4");
    rd_exp(2'd1, 8'h03, "R4");
    for (int i = 1; i < DEPTH; i++) rd_exp(2'd2, 8'h10 + 8'(i), "R3");
    rd_exp(2'd2, 8'h77, "R4");

    // R6 block mode accumulation
    wr(2'd3, 8'h01, "R6");
    wr(2'd0, 8'h20, "R6");
    push(8'h31, 3'b010, "R6");
    push(8'h32, 3'b001, "R6");
    rd(2'd2, "R6");
    rd_exp(2'd1, 8'h19, "R6");
    rd(2'd2, "R6");
    rd_exp(2'd1, 8'h18, "R6");
    wr(2'd3, 8'h02, "R6");
    rd_exp(2'd1, 8'h00, "R6");
    push(8'h33, 3'b100, "R6");
    wr(2'd3, 8'h02, "R6");
    rd_exp(2'd1, 8'h21, "R6");
    rd(2'd2, "R6");

    // R7 receiver RTS control, R9 full as request source
    wr(2'd3, 8'h01, "R7");
    wr(2'd0, 8'hC0, "R7");
    for (int i = 0; i < DEPTH; i++) push(8'h40 + 8'(i), 3'b000, "R7");
    #1 check("R9", {7'd0, irq_o}, 8'h01);
    start_det_i = 1; cycle("R7");
    #1 check("R7", {7'd0, rts_o}, 8'h00);
    cycle("R7");
    rd(2'd2, "R7");
    #1 check("R7", {7'd0, rts_o}, 8'h00);
    cycle("R7");
    #1 check("R7", {7'd0, rts_o}, 8'h01);
    #1 check("R9", {7'd0, irq_o}, 8'h00);
    push(8'h50, 3'b000, "R7");
    start_det_i = 1; cycle("R7");
    #1 check("R7", {7'd0, rts_o}, 8'h00);

    // R8 invalid combination releases RTS
    wr(2'd0, 8'h10, "R8");
    #1 check("R8", {7'd0, rts_o}, 8'h00);
    cycle("R8");
    #1 check("R8", {7'd0, rts_o}, 8'h01);
    start_det_i = 1; cycle("R8");
    #1 check("R8", {7'd0, rts_o}, 8'h01);
    wr(2'd3, 8'h01, "R8");
    wr(2'd0, 8'h00, "R8");
    start_det_i = 1; cycle("R8");
    #1 check("R8", {7'd0, rts_o}, 8'h01);

    // drain
    for (int i = 0; i < DEPTH; i++) rd(2'd2, "R3");
    rd_exp(2'd1, 8'h00, "R3");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule